// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a byte-wide flash interface. It works out when the device has finished an internal program or erase operation. After a start pulse it reads the device's status byte again and again through a synchronous request/valid read port. Bit 6 of the byte flips on every read while the device is busy and stops flipping once the operation is over. The poller compares bit 6 of two fresh reads. If the bit stayed put, the operation is complete. If it flipped and bit 5 (the device's timeout indication) is clear, the poller tries another pair of reads. If it flipped and bit 5 is set, the poller takes one more confirming pair, because bit 6 may have settled in the same cycle that bit 5 rose.

A program check polls the byte address being written. An erase check may poll any location, so the block presents a fixed parameter address instead. A programmable limit on the number of polling pairs turns a device that never settles into a failure rather than a hang. The result comes out as a one-cycle `done` pulse together with `pass` or `fail`, which stay valid until the next accepted start.

Top module: `tbit_poller`

## Requirements
- R1: Out of reset, `done`, `pass`, `fail` and `rd_req` are all 0.
- R2: A start accepted while idle latches the read address. This is `tgt_addr` when `erase_mode` is 0 (program) and the parameter `ERASE_ADDR` (default 0) when `erase_mode` is 1. Every read of that operation uses the latched address.
- R3: Once `rd_req` is raised, it stays high and `rd_addr` stays stable until a cycle in which `rd_valid` is high. The byte on `rd_data` in that cycle is the read result.
- R4: A check is two consecutive reads. If bit 6 is equal in both, the operation ends with pass.
- R5: If bit 6 differs and bit 5 of the second read of the pair is 0, a new pair of reads follows. This applies unless the limit of R8 is reached. Bit 5 of the first read has no effect.
- R6: If bit 6 differs and bit 5 of the second read is 1, one recheck pair follows. Equal bit 6 in the recheck gives pass. The recheck is taken even when the poll limit of R8 has been reached.
- R7: If bit 6 differs in the recheck pair, the result is fail, whatever bit 5 shows.
- R8: Polling pairs are numbered from 1. A toggling pair with bit 5 = 0 whose number is at least `max_polls` ends with fail. A `max_polls` of 0 behaves as 1.
- R9: `done` is high for exactly one cycle per operation. Exactly one of `pass`/`fail` is high with it, and both hold their values until the next accepted start, which clears them.
- R10: A start pulse while an operation is running is ignored. The address, mode and limit of the running operation do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted when idle) |
| erase_mode | input | 1 | 1 = erase check, 0 = program check |
| tgt_addr | input | AW | Byte address being programmed |
| max_polls | input | CW | Maximum number of polling pairs |
| rd_req | output | 1 | Read request, held until data valid |
| rd_addr | output | AW | Read address |
| rd_data | input | 8 | Status byte returned by the device |
| rd_valid | input | 1 | `rd_data` holds the requested byte |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed successfully |
| fail | output | 1 | Device timeout confirmed or poll limit hit |

## Verification
The bench goes after the case where bit 6 settles in the same pair that bit 5 rises. A poller that fails on the first bit-5 sighting would report fail where pass is due. It also checks that bit 5 is only looked at on the second read. A design that reads it from the first read would enter the recheck path too early. The poll limit is exercised at 0, exactly at the limit and one pair short of it, which exposes off-by-one counting. A design that lets the limit override a pending recheck would fail there. Back-to-back starts and slow, multi-cycle read latencies show whether an address switches mid-read or a busy start is accepted. Either one shows up as a wrong address or a wrong read count at the flash model.

// File: rtl/tbit_pkg.sv
package tbit_pkg;

    localparam int BUSY_BIT = 6;
    localparam int TMO_BIT  = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND
    } poll_st_t;

    typedef enum logic [1:0] {
        V_AGAIN,
        V_RECHECK,
        V_PASS,
        V_FAIL
    } verdict_t;

    typedef struct packed {
        logic busy_flip;
        logic timeout;
    } status_t;

    function automatic status_t decode_status(input logic [7:0] b);
        status_t s;
        s.busy_flip = b[BUSY_BIT];
        s.timeout   = b[TMO_BIT];
        return s;
    endfunction

    function automatic logic toggled(input status_t a, input status_t b);
        return a.busy_flip != b.busy_flip;
    endfunction

endpackage

// File: rtl/tbit_rd_port.sv
module tbit_rd_port
    import tbit_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          want,
    input  logic          keep_first,
    input  logic [AW-1:0] addr_in,
    input  logic [7:0]    rd_data,
    input  logic          rd_valid,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          got,
    output status_t       now_s,
    output status_t       first_s
);

    assign rd_req  = want;
    assign rd_addr = addr_in;
    assign got     = want & rd_valid;
    assign now_s   = decode_status(rd_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            first_s <= '0;
        end else if (keep_first && got) begin
            first_s <= now_s;
        end
    end

endmodule

// File: rtl/tbit_budget.sv
module tbit_budget #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          bump,
    input  logic [CW-1:0] limit,
    output logic          last
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt;
    logic [CW:0]   nxt;

    assign nxt  = {1'b0, cnt} + 1'b1;
    assign last = nxt >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (bump && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tbit_judge.sv
module tbit_judge
    import tbit_pkg::*;
(
    input  status_t  first_s,
    input  status_t  second_s,
    input  logic     in_recheck,
    input  logic     at_limit,
    output verdict_t verdict
);

    always_comb begin
        if (!toggled(first_s, second_s)) begin
            verdict = V_PASS;
        end else if (in_recheck) begin
            verdict = V_FAIL;
        end else if (second_s.timeout) begin
            verdict = V_RECHECK;
        end else if (at_limit) begin
            verdict = V_FAIL;
        end else begin
            verdict = V_AGAIN;
        end
    end

endmodule

// File: rtl/tbit_poller.sv
module tbit_poller
    import tbit_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          CW         = 16,
    parameter int unsigned ERASE_ADDR = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          erase_mode,
    input  logic [AW-1:0] tgt_addr,
    input  logic [CW-1:0] max_polls,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    input  logic          rd_valid,
    output logic          done,
    output logic          pass,
    output logic          fail
);

    localparam logic [AW-1:0] ERASE_A = AW'(ERASE_ADDR);

    poll_st_t      st;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] limit_q;
    logic          recheck_q;
    logic          got;
    logic          at_limit;
    logic          accept;
    status_t       now_s;
    status_t       first_s;
    verdict_t      verdict;

    assign accept = (st == ST_IDLE) && start;

    tbit_rd_port #(.AW(AW)) u_port (
        .clk        (clk),
        .rst        (rst),
        .want       (st != ST_IDLE),
        .keep_first (st == ST_FIRST),
        .addr_in    (addr_q),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .got        (got),
        .now_s      (now_s),
        .first_s    (first_s)
    );

    tbit_budget #(.CW(CW)) u_budget (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .bump  ((st == ST_SECOND) && got && (verdict == V_AGAIN)),
        .limit (limit_q),
        .last  (at_limit)
    );

    tbit_judge u_judge (
        .first_s    (first_s),
        .second_s   (now_s),
        .in_recheck (recheck_q),
        .at_limit   (at_limit),
        .verdict    (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            addr_q    <= '0;
            limit_q   <= '0;
            recheck_q <= 1'b0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        addr_q    <= erase_mode ? ERASE_A : tgt_addr;
                        limit_q   <= max_polls;
                        recheck_q <= 1'b0;
                        pass      <= 1'b0;
                        fail      <= 1'b0;
                        st        <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (got) st <= ST_SECOND;
                end
                ST_SECOND: begin
                    if (got) begin
                        case (verdict)
                            V_PASS: begin
                                pass <= 1'b1;
                                done <= 1'b1;
                                st   <= ST_IDLE;
                            end
                            V_FAIL: begin
                                fail <= 1'b1;
                                done <= 1'b1;
                                st   <= ST_IDLE;
                            end
                            V_RECHECK: begin
                                recheck_q <= 1'b1;
                                st        <= ST_FIRST;
                            end
                            default: st <= ST_FIRST;
                        endcase
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tbit_poller_chk.sv
module tbit_poller_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_valid,
    input logic          done,
    input logic          pass,
    input logic          fail
);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    // R9
    done_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass != fail));

    // R9
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (done || ($stable(pass) && $stable(fail))));

endmodule

bind tbit_poller tbit_poller_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_tbit_poller.sv
`timescale 1ns/1ps
module test_tbit_poller;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          erase_mode = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [CW-1:0] max_polls = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = 8'h00;
    logic          rd_valid = 1'b0;
    logic          done, pass, fail;

    always #2 clk = ~clk;

    tbit_poller #(.AW(AW), .CW(CW)) i_tbit_poller (
        .clk(clk), .rst(rst), .start(start), .erase_mode(erase_mode),
        .tgt_addr(tgt_addr), .max_polls(max_polls), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .pass(pass), .fail(fail)
    );

    typedef struct {
        bit    exp_pass;
        int    exp_reads;
        string req;
    } exp_t;

    int            tests = 0;
    int            fails = 0;
    byte unsigned  fq[$];
    exp_t          sb[$];
    int            reads = 0;
    int            addr_err = 0;
    int            overrun = 0;
    int            lat = 1;
    int            wcnt = 0;
    bit            waiting = 0;
    int            done_seen = 0;
    logic [AW-1:0] exp_addr = '0;
    logic [AW-1:0] hold_addr = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // flash model: answers each request after lat cycles
    always @(negedge clk) begin
        if (rst) begin
            rd_valid = 1'b0;
            waiting  = 0;
            wcnt     = 0;
        end else if (rd_valid) begin
            rd_valid = 1'b0;
            waiting  = 0;
        end else if (rd_req) begin
            if (!waiting) begin
                waiting   = 1;
                hold_addr = rd_addr;
                wcnt      = 0;
            end else if (rd_addr !== hold_addr) begin
                addr_err++;
            end
            wcnt++;
            if (wcnt >= lat) begin
                if (rd_addr !== exp_addr) addr_err++;
                if (fq.size() > 0) rd_data = fq.pop_front();
                else begin
                    rd_data = 8'h00;
                    overrun++;
                end
                rd_valid = 1'b1;
                reads++;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(0, "R9", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(pass == e.exp_pass, e.req, "pass", int'(pass), int'(e.exp_pass));
                check(fail == !e.exp_pass, e.req, "fail", int'(fail), int'(!e.exp_pass));
                check(reads == e.exp_reads && overrun == 0, e.req, "reads",
                      reads, e.exp_reads);
                check(addr_err == 0, "R2/R3 address", "errors", addr_err, 0);
            end
            done_seen++;
        end
    end

    task automatic run_op(input bit er, input logic [AW-1:0] a, input int mx,
                          input int l, input byte unsigned bytes[$],
                          input bit ep, input int n_reads, input string req,
                          input bit poke);
        exp_t e;
        int d0;
        fq       = bytes;
        reads    = 0;
        addr_err = 0;
        overrun  = 0;
        lat      = l;
        exp_addr = er ? '0 : a;
        e.exp_pass  = ep;
        e.exp_reads = n_reads;
        e.req       = req;
        sb.push_back(e);
        d0 = done_seen;
        @(negedge clk);
        erase_mode = er;
        tgt_addr   = a;
        max_polls  = CW'(mx);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        if (poke) begin
            // R10: busy start with other settings must be ignored
            repeat (3) @(negedge clk);
            start      = 1'b1;
            erase_mode = !er;
            tgt_addr   = ~a;
            max_polls  = '0;
            @(negedge clk);
            start      = 1'b0;
        end
        while (done_seen == d0) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R9", "done width", int'(done), 0);
        repeat (2) @(negedge clk);
        check(pass == ep && fail == !ep, "R9", "verdict held", int'(pass), int'(ep));
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!done && !pass && !fail && !rd_req, "R1", "reset outputs",
              int'({done, pass, fail, rd_req}), 0);

        // R4 settled on first pair
        run_op(0, 16'h1234, 8, 1, '{8'h40, 8'h40}, 1, 2, "R4", 0);
        // R5 one toggling pair then settle, slow reads
        run_op(0, 16'h0F0F, 8, 3, '{8'h40, 8'h00, 8'h00, 8'h00}, 1, 4, "R5", 0);
        // R5 bit 5 on first read only is ignored
        run_op(0, 16'h0101, 8, 2, '{8'h60, 8'h00, 8'h00, 8'h00}, 1, 4, "R5", 0);
        // R2 erase uses fixed address
        run_op(1, 16'h5A5A, 8, 1, '{8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00},
               1, 6, "R2", 0);
        // R6 timeout seen, recheck settles
        run_op(0, 16'h2222, 8, 1, '{8'h00, 8'h60, 8'h20, 8'h20}, 1, 4, "R6", 0);
        // R7 recheck still toggling
        run_op(0, 16'h3333, 8, 2, '{8'h40, 8'h20, 8'h40, 8'h00}, 0, 4, "R7", 0);
        // R7 recheck toggling with bit 5 set again
        run_op(0, 16'h3434, 8, 1, '{8'h00, 8'h60, 8'h00, 8'h60}, 0, 4, "R7", 0);
        // R8 limit of 3 pairs exhausted
        run_op(0, 16'h4444, 3, 1, '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40},
               0, 6, "R8", 0);
        // R8 limit 0 behaves as 1
        run_op(0, 16'h4545, 0, 1, '{8'h00, 8'h40}, 0, 2, "R8", 0);
        // R8 settle on the last allowed pair
        run_op(0, 16'h4646, 3, 1, '{8'h00, 8'h40, 8'h40, 8'h00, 8'h40, 8'h40},
               1, 6, "R8", 0);
        // R6 recheck taken although limit reached
        run_op(0, 16'h5555, 1, 1, '{8'h00, 8'h60, 8'h40, 8'h40}, 1, 4, "R6", 0);
        // R10 start while busy ignored
        run_op(0, 16'h6666, 8, 3, '{8'h40, 8'h00, 8'h00, 8'h00}, 1, 4, "R10", 1);

        check(sb.size() == 0, "R9", "pending results", sb.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule